// File: doc/BRIEF.md
# I/O Port Select and Data Transceiver Control

This block watches the address and control strobes of an 8-bit CPU with separate memory and I/O cycles and decides, with no clock, whether the current cycle addresses one external peripheral port. It drives an active-low chip select for the peripheral. It also drives the output-enable and direction pins of a bidirectional data-bus transceiver placed between the host and that peripheral.

The port is configured by a 16-bit match value and a 16-bit compare mask. A mask bit of 1 makes the matching address bit take part in the compare. A mask bit of 0 makes that bit a don't-care. The host has on-board devices that use single address lines (A0, A1, A3, A4) as active-low selects. Any cycle with one of those lines low is therefore never claimed. A match/mask pair that could ever claim such an address is flagged on a configuration-error output, and while that flag is high the port is never selected. A parameter chooses between two builds. The full build uses a bidirectional transceiver gated by the complete decode. The write-only build uses a one-way buffer toward the peripheral and leaves decoding to the far side.

Top module: `io_port_select`

## Requirements
- R1: The chip select `cs_n` is low only while `iorq_n` is low and `mreq_n` is high.
- R2: For a qualified I/O cycle with a legal configuration, `cs_n` is low exactly when `((addr ^ port_match) & port_mask) == 0` over all 16 address bits.
- R3: Whenever any of address bits 0, 1, 3 or 4 (mask 16'h001B) is low, `cs_n` is high.
- R4: `cfg_err` is high exactly when `16'h001B & ~(port_mask & port_match)` is nonzero; while it is high, `cs_n` is high for every address.
- R5: While `rfsh_n` is low, `cs_n` and `xcvr_oe_n` are both high.
- R6: While `m1_n` is low (interrupt acknowledge), `cs_n` and `xcvr_oe_n` are both high.
- R7: In the full build (WRITE_ONLY=0), `xcvr_oe_n` equals `cs_n`, so a read drives the CPU data bus only for a decoded port.
- R8: In the full build, `xcvr_dir` is 1 (peripheral toward CPU) only while `cs_n` is low and `rd_n` is low. Otherwise it is 0 (CPU toward peripheral), including whenever the transceiver is disabled.
- R9: In the write-only build (WRITE_ONLY=1), `xcvr_oe_n` is low exactly on I/O cycles with `wr_n` low, `rd_n` high, `m1_n` high and `rfsh_n` high, for any address. `xcvr_dir` is always 0.
- R10: With `port_match`=16'h001F and `port_mask`=16'h00FF, `cfg_err` is 0 and every address whose low byte is 8'h1F is selected on an I/O cycle.
- R11: All outputs follow the inputs combinationally, with no clock cycles of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | CPU address bus |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| rfsh_n | input | 1 | Refresh marker, active low |
| port_match | input | 16 | Port address to match |
| port_mask | input | 16 | Compare mask, 1 = bit compared |
| cs_n | output | 1 | Peripheral chip select, active low |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward CPU |
| cfg_err | output | 1 | Match/mask could claim a host-reserved port |

## Verification
Every output is due in the same cycle as the stimulus that causes it, with zero clock cycles of delay. The bench therefore applies each input vector, lets a short fixed settling delay pass, and compares all outputs before the next vector. It does not wait for any clock edge. The sweeps cover every 16-bit address under the 0x1F port setting, every combination of the six strobes at several addresses, and a long pseudo-random walk over match, mask and address values. The checks are made on two instances, one for each build.

// File: rtl/io_port_select.sv
module io_port_select #(
  parameter int          AW         = 16,
  parameter logic [15:0] RSV_LINES  = 16'h001B,
  parameter bit          WRITE_ONLY = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          iorq_n,
  input  logic          mreq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          m1_n,
  input  logic          rfsh_n,
  input  logic [AW-1:0] port_match,
  input  logic [AW-1:0] port_mask,
  output logic          cs_n,
  output logic          xcvr_oe_n,
  output logic          xcvr_dir,
  output logic          cfg_err
);

  localparam logic [AW-1:0] RSV = AW'(RSV_LINES);

  logic io_cycle, qual, hit, rsv_high, sel, wr_only_cycle;

  assign io_cycle = !iorq_n && mreq_n;
  assign qual     = io_cycle && m1_n && rfsh_n;
  assign hit      = ((addr ^ port_match) & port_mask) == '0;
  assign rsv_high = (addr & RSV) == RSV;
  assign cfg_err  = |(RSV & ~(port_mask & port_match));
  assign sel      = qual && hit && rsv_high && !cfg_err;
  assign cs_n     = !sel;

  assign wr_only_cycle = qual && rd_n && !wr_n;

  generate
    if (WRITE_ONLY) begin : g_oneway
      assign xcvr_oe_n = !wr_only_cycle;
      assign xcvr_dir  = 1'b0;
    end else begin : g_bidir
      assign xcvr_oe_n = !sel;
      assign xcvr_dir  = sel && !rd_n;
    end
  endgenerate

  always_comb begin
    a_r1_io_only: assert (cs_n || (!iorq_n && mreq_n))
      else $error("select outside I/O cycle");
    a_r3_reserved_lines: assert (cs_n || ((addr & RSV) == RSV))
      else $error("select with reserved line low");
    a_r4_cfg_blocks: assert (!cfg_err || cs_n)
      else $error("select with bad configuration");
    a_r5_refresh: assert (rfsh_n || (cs_n && xcvr_oe_n))
      else $error("active during refresh");
    a_r6_int_ack: assert (m1_n || (cs_n && xcvr_oe_n))
      else $error("active during acknowledge");
    a_r8_dir_read: assert (!xcvr_dir || (!xcvr_oe_n && !rd_n))
      else $error("direction toward CPU without read");
  end

endmodule

// File: tb/sim_io_port_select.sv
module sim_io_port_select;
  logic clk = 0;
  logic rst = 1;
  always #10 clk = ~clk;

  logic [15:0] addr, pm, pk;
  logic iorq_n, mreq_n, rd_n, wr_n, m1_n, rfsh_n;
  logic cs0, oe0, dir0, err0, cs1, oe1, dir1, err1;

  int checks = 0, fails = 0;
  bit done = 0;

  io_port_select #(.WRITE_ONLY(1'b0)) u0 (
    .addr(addr), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .rfsh_n(rfsh_n), .port_match(pm), .port_mask(pk),
    .cs_n(cs0), .xcvr_oe_n(oe0), .xcvr_dir(dir0), .cfg_err(err0));

  io_port_select #(.WRITE_ONLY(1'b1)) u1 (
    .addr(addr), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .rfsh_n(rfsh_n), .port_match(pm), .port_mask(pk),
    .cs_n(cs1), .xcvr_oe_n(oe1), .xcvr_dir(dir1), .cfg_err(err1));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h match=%h mask=%h ctl=%b%b%b%b%b%b actual=%b expected=%b",
               req, addr, pm, pk, iorq_n, mreq_n, rd_n, wr_n, m1_n, rfsh_n, act, exp);
    end
  endtask

  task automatic eval_all(input string tag);
    logic q, e, s, w;
    q = !iorq_n && mreq_n && m1_n && rfsh_n;
    e = (16'h001B & ~(pk & pm)) != 0;
    s = q && (((addr ^ pm) & pk) == 0) && ((addr & 16'h001B) == 16'h001B) && !e;
    w = q && rd_n && !wr_n;
    #2;
    // R1 R2 R3 R4 R5 R6 R7 R8 R11: full build, sampled with no clock wait
    chk({tag, " full"}, {cs0, oe0, dir0, err0}, {!s, !s, s && !rd_n, e});
    // R9: write-only build
    chk({tag, " R9"}, {cs1, oe1, dir1, err1}, {!s, !w, 1'b0, e});
    #1;
  endtask

  task automatic set_ctl(input logic [5:0] c);
    {iorq_n, mreq_n, rd_n, wr_n, m1_n, rfsh_n} = c;
  endtask

  initial begin
    logic [31:0] lfsr;
    addr = 16'hFFFF; pm = 16'h001F; pk = 16'h00FF;
    set_ctl(6'b111111);
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // reset / idle state
    #2 chk("R1 idle", {cs0, oe0, dir0, err0}, 4'b1100);
    #1;

    // R10: full address sweep, port 0x1F, read then write
    for (int a = 0; a < 65536; a++) begin
      addr = 16'(a);
      set_ctl((a % 2 == 0) ? 6'b010111 : 6'b011011);
      eval_all((addr[7:0] == 8'h1F) ? "R10 hit" : "R2 miss");
    end

    // R1 R5 R6 R8: every strobe combination at several addresses
    for (int k = 0; k < 4; k++) begin
      addr = (k == 0) ? 16'h001F : (k == 1) ? 16'hFE1F : (k == 2) ? 16'h001E : 16'h0017;
      for (int c = 0; c < 64; c++) begin
        set_ctl(6'(c));
        eval_all("R5 R6 R8 strobes");
      end
    end

    // R4: known bad configurations
    pm = 16'h001D; pk = 16'hFFFF; addr = 16'h001D; set_ctl(6'b010111);
    eval_all("R4 match bit low");
    pm = 16'h001F; pk = 16'h00F7; addr = 16'h001F;
    eval_all("R4 mask hole");

    // R2 R3 R4 upper byte and random walk
    pm = 16'hA55F; pk = 16'hFF1F; addr = 16'hA55F; set_ctl(6'b010111);
    eval_all("R2 upper byte hit");
    addr = 16'hA45F;
    eval_all("R2 upper byte miss");
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 20000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pm = lfsr[15:0] | ((i % 3 != 0) ? 16'h001B : 16'h0);
      pk = lfsr[31:16] | ((i % 5 != 0) ? 16'h001B : 16'h0);
      addr = (i % 2 == 0) ? ((pm & pk) | (lfsr[23:8] & ~pk)) : lfsr[27:12];
      set_ctl({1'b0, 1'b1, lfsr[4], !lfsr[4], lfsr[9] | lfsr[2], lfsr[7] | lfsr[3]});
      eval_all("R2 R3 R4 walk");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 190000; n++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule